// File: doc/BRIEF.md
# Multi-Engine Barrier Fence Sequencer

This block holds five engine sequencers at a common rendezvous point. Each engine sequencer raises a one-cycle request, and the block then walks that engine through four steps. It waits until the engine's outstanding-transfer queue reports it has drained. It posts one arrival on a single shared arrival counter. It waits until the counter reaches the current round threshold. It then gives the engine a one-cycle release pulse. The barrier is flat. Every participant increments the same counter and watches the same threshold, so all waiting engines leave in the same cycle.

Engines are addressed in an 8-slot engine-id space. A participation mask picks the five slots that take part. A request on any other slot has no effect, and an error flag is raised for one cycle.

A request made with the fence flag set runs a longer sequence: first barrier, re-arm, second barrier, final drain, release. The re-arm sets the counter back to zero and the threshold back to N. The two barriers around the re-arm make sure no engine posts into a counter that is still being cleared. The re-arm also keeps the accumulating counter from wrapping. Plain barriers in the meantime raise the threshold by N on every completed round.

Top module: `barrier_fence_seq`

## Requirements
- R1: Only the engine ids whose bit is set in the participation mask take part (default mask 0x6E: ids 1, 2, 3, 5 and 6, so N = 5), and no other id ever receives a release.
- R2: A participating engine posts its arrival only after its drain-done input has been seen high; while one participant's drain-done stays low, no engine is released.
- R3: Arrivals posted by several engines in the same cycle are all counted, so requests that arrive in groups across different cycles still complete the round.
- R4: Engines are released together, in the single cycle after the shared counter reaches the round threshold, and never while a participant has not yet arrived.
- R5: The release output of an engine is a one-cycle pulse. When all participants request in the same cycle with drain-done already high, the pulse is high in the third cycle after the cycle in which the request was sampled.
- R6: Every completed plain round raises the threshold by N above its previous value, so back-to-back plain rounds each need N new arrivals.
- R7: A fence request runs this sequence: barrier, then re-arm of the counter to zero and the threshold to N, then a second barrier, then a final drain. The engine's release waits on its drain-done after the second barrier.
- R8: A request on an id outside the mask changes no engine state and produces no release. The error output is high in the cycle after such a request is sampled, and low otherwise.
- R9: A request from an engine that is already in a barrier is ignored and does not start an extra round.
- R10: After synchronous reset, every release output and the error output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_IDS | Per-engine-id barrier request, sampled while that engine is idle |
| fence_i | input | NUM_IDS | Per-engine-id fence flag, taken together with the request |
| drain_done_i | input | NUM_IDS | Per-engine-id indication that the in-flight queue is empty |
| rel_o | output | NUM_IDS | Per-engine-id one-cycle release pulse |
| req_err_o | output | 1 | High for one cycle after a request on a non-participating id |

## Verification
The first pattern has all five engines request together with their queues already drained. This fixes the exact release latency and shows that the release is a single pulse. The second pattern holds one engine's drain-done low, which tells a design that posts only after draining apart from one that posts early. The third pattern spreads the requests over several cycles, with some of them landing in the same cycle. This separates a counter that sums simultaneous arrivals from one that loses some, and also exercises the threshold rising from round to round. Further patterns cover:
- requests on ids outside the mask;
- a second request while an engine is still in a round;
- a fence in which one engine's final drain is held back;
- a round with one participant missing until late.

Each of these shows at the release outputs whether the block obeyed the rule or broke it.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_POST,
    ST_WAIT,
    ST_REL
  } eng_st_t;

  localparam logic [1:0] PH_BAR1 = 2'd0;
  localparam logic [1:0] PH_BAR2 = 2'd1;
  localparam logic [1:0] PH_TAIL = 2'd2;

  function automatic int count_bits(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/bfs_engine_ctl.sv
module bfs_engine_ctl
  import bfs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic fence_i,
  input  logic drain_done_i,
  input  logic round_done_i,
  output logic post_o,
  output logic fence_first_o,
  output logic rel_o
);

  eng_st_t    st_q;
  logic       fence_q;
  logic [1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      fence_q <= 1'b0;
      phase_q <= PH_BAR1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            fence_q <= fence_i;
            phase_q <= PH_BAR1;
            st_q    <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (drain_done_i) st_q <= (phase_q == PH_TAIL) ? ST_REL : ST_POST;
        end
        ST_POST: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (round_done_i) begin
            if (fence_q && phase_q == PH_BAR1) begin
              phase_q <= PH_BAR2;
              st_q    <= ST_POST;
            end else if (fence_q && phase_q == PH_BAR2) begin
              phase_q <= PH_TAIL;
              st_q    <= ST_DRAIN;
            end else begin
              st_q <= ST_REL;
            end
          end
        end
        ST_REL:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign post_o        = (st_q == ST_POST);
  assign fence_first_o = (st_q == ST_WAIT) && fence_q && (phase_q == PH_BAR1);
  assign rel_o         = (st_q == ST_REL);

endmodule

// File: rtl/bfs_arrival_ctr.sv
module bfs_arrival_ctr #(
  parameter int NUM_IDS = 8,
  parameter int CNT_W   = 8,
  parameter int N       = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IDS-1:0] post_i,
  input  logic               rearm_i,
  output logic               done_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   goal_o
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(N);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] goal_q;
  logic [CNT_W-1:0] arrivals;

  always_comb begin
    arrivals = '0;
    for (int i = 0; i < NUM_IDS; i++) arrivals = arrivals + CNT_W'(post_i[i]);
  end

  assign done_o = (cnt_q >= goal_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      goal_q <= STEP;
    end else if (done_o && rearm_i) begin
      cnt_q  <= '0;
      goal_q <= STEP;
    end else begin
      cnt_q <= cnt_q + arrivals;
      if (done_o) goal_q <= goal_q + STEP;
    end
  end

  assign cnt_o  = cnt_q;
  assign goal_o = goal_q;

endmodule

// File: rtl/barrier_fence_seq.sv
module barrier_fence_seq #(
  parameter int                 NUM_IDS   = 8,
  parameter logic [NUM_IDS-1:0] PART_MASK = 8'h6E,
  parameter int                 CNT_W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IDS-1:0] req_i,
  input  logic [NUM_IDS-1:0] fence_i,
  input  logic [NUM_IDS-1:0] drain_done_i,
  output logic [NUM_IDS-1:0] rel_o,
  output logic               req_err_o
);

  localparam int N = bfs_pkg::count_bits(32'(PART_MASK));

  logic [NUM_IDS-1:0] post_w;
  logic [NUM_IDS-1:0] ffirst_w;
  logic               done_w;
  logic               rearm_w;
  logic [CNT_W-1:0]   cnt_w;
  logic [CNT_W-1:0]   goal_w;
  logic               err_q;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    if (PART_MASK[g]) begin : g_eng
      bfs_engine_ctl u_eng (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req_i[g]),
        .fence_i      (fence_i[g]),
        .drain_done_i (drain_done_i[g]),
        .round_done_i (done_w),
        .post_o       (post_w[g]),
        .fence_first_o(ffirst_w[g]),
        .rel_o        (rel_o[g])
      );
    end else begin : g_off
      assign post_w[g]   = 1'b0;
      assign ffirst_w[g] = 1'b0;
      assign rel_o[g]    = 1'b0;
    end
  end

  assign rearm_w = |ffirst_w;

  bfs_arrival_ctr #(
    .NUM_IDS(NUM_IDS),
    .CNT_W  (CNT_W),
    .N      (N)
  ) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .post_i (post_w),
    .rearm_i(rearm_w),
    .done_o (done_w),
    .cnt_o  (cnt_w),
    .goal_o (goal_w)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= |(req_i & ~PART_MASK);
  end

  assign req_err_o = err_q;

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int                 NUM_IDS   = 8,
  parameter logic [NUM_IDS-1:0] PART_MASK = 8'h6E,
  parameter int                 CNT_W     = 8,
  parameter int                 N         = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IDS-1:0] req_i,
  input logic [NUM_IDS-1:0] rel_o,
  input logic               req_err_o,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   goal,
  input logic               done,
  input logic               rearm
);

  a_r1_no_foreign_release: assert property (@(posedge clk) disable iff (rst)
    (rel_o & ~PART_MASK) == '0);

  a_r8_err_raised: assert property (@(posedge clk) disable iff (rst)
    (|(req_i & ~PART_MASK)) |=> req_err_o);

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
    !(|(req_i & ~PART_MASK)) |=> !req_err_o);

  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= goal);

  a_r7_rearm_zero: assert property (@(posedge clk) disable iff (rst)
    (done && rearm) |=> (cnt == '0 && goal == CNT_W'(N)));

  a_r6_goal_step: assert property (@(posedge clk) disable iff (rst)
    (done && !rearm) |=> (goal == $past(goal) + CNT_W'(N)));

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_pulse
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
      rel_o[i] |=> !rel_o[i]);
  end

endmodule

bind barrier_fence_seq bfs_checker #(
  .NUM_IDS  (NUM_IDS),
  .PART_MASK(PART_MASK),
  .CNT_W    (CNT_W),
  .N        (N)
) u_bfs_chk (
  .clk      (clk),
  .rst      (rst),
  .req_i    (req_i),
  .rel_o    (rel_o),
  .req_err_o(req_err_o),
  .cnt      (cnt_w),
  .goal     (goal_w),
  .done     (done_w),
  .rearm    (rearm_w)
);

// File: tb/test_barrier_fence_seq.sv
`timescale 1ns/1ps
module test_barrier_fence_seq;

  localparam logic [7:0] MASK = 8'h6E;
  localparam int NP = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0;
  logic [7:0] fence = '0;
  logic [7:0] drain = 8'hFF;
  logic [7:0] rel;
  logic       err;

  always #4 clk = ~clk;

  barrier_fence_seq i_barrier_fence_seq (
    .clk(clk), .rst(rst), .req_i(req), .fence_i(fence),
    .drain_done_i(drain), .rel_o(rel), .req_err_o(err)
  );

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R10";
  bit    chk_on = 1'b0;
  int    rel_cnt [8];
  int    cycles = 0;

  // Reference model: stage 0 idle, 1 drain, 2 post, 3 wait, 4 release
  int   m_stage [8];
  int   m_phase [8];
  bit   m_fence [8];
  int   m_cnt, m_goal;
  logic [7:0] m_rel;
  logic       m_err;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_stage[i] = 0; m_phase[i] = 0; m_fence[i] = 0; end
      m_cnt = 0; m_goal = NP; m_err = 0;
    end else begin
      bit done, first;
      int posts;
      done = (m_cnt >= m_goal);
      first = 0; posts = 0;
      for (int i = 0; i < 8; i++) if (MASK[i]) begin
        if (m_stage[i] == 3 && m_fence[i] && m_phase[i] == 0) first = 1;
        if (m_stage[i] == 2) posts++;
      end
      for (int i = 0; i < 8; i++) if (MASK[i]) begin
        case (m_stage[i])
          0: if (req[i]) begin m_fence[i] = fence[i]; m_phase[i] = 0; m_stage[i] = 1; end
          1: if (drain[i]) m_stage[i] = (m_phase[i] == 2) ? 4 : 2;
          2: m_stage[i] = 3;
          3: if (done) begin
               if (m_fence[i] && m_phase[i] == 0) begin m_phase[i] = 1; m_stage[i] = 2; end
               else if (m_fence[i] && m_phase[i] == 1) begin m_phase[i] = 2; m_stage[i] = 1; end
               else m_stage[i] = 4;
             end
          default: m_stage[i] = 0;
        endcase
      end
      if (done && first) begin m_cnt = 0; m_goal = NP; end
      else begin m_cnt += posts; if (done) m_goal += NP; end
      m_err = |(req & ~MASK);
    end
    for (int i = 0; i < 8; i++) m_rel[i] = (m_stage[i] == 4);
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk(rel === m_rel, {cur_req, " release vs model"}, int'(rel), int'(m_rel));
      chk(err === m_err, {cur_req, " error vs model"}, int'(err), int'(m_err));
      for (int i = 0; i < 8; i++) if (rel[i] === 1'b1) rel_cnt[i]++;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      finish_run();
    end
  end

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [7:0] m, input logic f);
    @(negedge clk);
    req = m; fence = f ? m : '0;
    @(negedge clk);
    req = '0; fence = '0;
  endtask

  task automatic check_counts(input int expv, input string tag);
    for (int i = 0; i < 8; i++)
      if (MASK[i]) chk(rel_cnt[i] == expv, tag, rel_cnt[i], expv);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rel_cnt[i] = 0;
    wait_n(3);
    rst = 1'b0;
    chk(rel == 8'h00, "R10 release after reset", int'(rel), 0);
    chk(err == 1'b0, "R10 error after reset", int'(err), 0);
    chk_on = 1'b1;

    // R5: all together, queues drained
    cur_req = "R5";
    pulse_req(MASK, 1'b0);
    wait_n(2);
    chk(rel == 8'h00, "R5 no early release", int'(rel), 0);
    wait_n(1);
    chk(rel == MASK, "R5 release cycle", int'(rel), int'(MASK));
    wait_n(1);
    chk(rel == 8'h00, "R5 single pulse", int'(rel), 0);
    wait_n(6);
    check_counts(1, "R4 all released once");

    // R2: engine 6 not drained
    cur_req = "R2";
    drain = 8'hBF;
    pulse_req(MASK, 1'b0);
    wait_n(15);
    check_counts(1, "R2 held by undrained engine");
    drain = 8'hFF;
    cur_req = "R6";
    wait_n(10);
    check_counts(2, "R6 second round completes");

    // R3: staggered and grouped arrivals
    cur_req = "R3";
    pulse_req(8'h06, 1'b0);
    pulse_req(8'h28, 1'b0);
    wait_n(2);
    pulse_req(8'h40, 1'b0);
    wait_n(10);
    check_counts(3, "R3 grouped arrivals counted");

    // R8: non-participant requests
    cur_req = "R8";
    @(negedge clk); req = 8'h91;
    @(negedge clk); req = 8'h00;
    chk(err == 1'b1, "R8 error flag", int'(err), 1);
    wait_n(10);
    chk(err == 1'b0, "R8 error cleared", int'(err), 0);
    check_counts(3, "R8 no release from foreign ids");

    // R9: request while busy
    cur_req = "R9";
    pulse_req(MASK, 1'b0);
    pulse_req(MASK, 1'b0);
    wait_n(15);
    check_counts(4, "R9 repeat request ignored");

    // R7: fence with engine 3's final drain held back
    cur_req = "R7";
    pulse_req(MASK, 1'b1);
    @(negedge clk); drain = 8'hF7;
    wait_n(20);
    chk(rel_cnt[3] == 4, "R7 release waits on final drain", rel_cnt[3], 4);
    chk(rel_cnt[1] == 5, "R7 other engines released", rel_cnt[1], 5);
    drain = 8'hFF;
    wait_n(6);
    check_counts(5, "R7 fence complete");

    // R6: plain round after fence re-arm
    cur_req = "R6";
    pulse_req(MASK, 1'b0);
    wait_n(10);
    check_counts(6, "R6 round after re-arm");

    // R4: one participant missing
    cur_req = "R4";
    pulse_req(8'h4E, 1'b0);
    wait_n(20);
    check_counts(6, "R4 no release with missing arrival");
    pulse_req(8'h20, 1'b0);
    wait_n(10);
    check_counts(7, "R4 release after last arrival");

    cur_req = "R1";
    chk(rel_cnt[0] + rel_cnt[4] + rel_cnt[7] == 0, "R1 foreign ids never released",
        rel_cnt[0] + rel_cnt[4] + rel_cnt[7], 0);
    finish_run();
  end

endmodule